// File: doc/BRIEF.md
# Overload Comparator with Glitch-Qualified Trip

This block watches a stream of unsigned samples from a fast, low-decimation sinc filter that decodes a current or voltage bit stream. Each accepted sample is checked against a programmable lower and upper limit. A sample outside that band counts as a violation. A short run of violations is often only switching noise. For that reason a trip is raised only when enough violations build up inside a sliding window of recent samples. The trip output is a single-cycle pulse, meant for a fast shutdown path. A sticky flag records the event until software clears it.

For diagnosis after a fault, a small circular buffer keeps the most recent samples. It stops taking new samples at the moment the trip fires, so the samples that led up to the fault stay available through an indexed read port. After reset, the comparison stays blind for a programmable number of samples while the upstream filter settles. This keeps start-up transients from causing a trip. A mask input suppresses trips but leaves the window and the history running.

Top module: `ovl_trip_monitor`

## Requirements
- R1: After reset, trip_pulse and trip_flag are low.
- R2: A sample is a violation only when it is strictly greater than lim_hi or strictly less than lim_lo. A sample equal to either limit is in range.
- R3: The first SETTLE_SAMPLES valid samples after reset never count as violations, whatever their value.
- R4: On a valid sample, the violations among the last W valid samples are counted, the current one included. If that count is at least viol_need and trip_flag is low, trip_pulse is high for exactly the one cycle after that sample's clock edge.
- R5: The effective window W is win_len clamped to the range 1..WIN_MAX, so a win_len of 0 acts as 1. A viol_need of 0 never trips.
- R6: trip_flag rises together with trip_pulse and stays high until trip_clear. trip_clear also empties the violation window. Samples are not presented in the same cycle as trip_clear.
- R7: While trip_mask is high, neither trip_pulse nor trip_flag is raised. The violation window and the history keep updating during that time.
- R8: hist_data shows the sample at hist_idx one cycle after the index is sampled, where index 0 is the most recent of the last HIST_DEPTH valid samples. The tripping sample is the last one stored. The buffer then holds still until trip_clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Unsigned filter sample |
| lim_lo | input | SAMPLE_W | Lower in-range limit |
| lim_hi | input | SAMPLE_W | Upper in-range limit |
| viol_need | input | clog2(WIN_MAX+1) | Violations needed to trip |
| win_len | input | clog2(WIN_MAX+1) | Window length in samples |
| trip_mask | input | 1 | Suppress trips |
| trip_clear | input | 1 | Clear flag, window and history freeze |
| hist_idx | input | clog2(HIST_DEPTH) | History read index, 0 = newest |
| trip_pulse | output | 1 | One-cycle trip pulse |
| trip_flag | output | 1 | Sticky trip status |
| hist_data | output | SAMPLE_W | History read data |

## Verification
The bench builds the block with WIN_MAX of 8, SETTLE_SAMPLES of 4 and HIST_DEPTH of 8. With these values a win_len of 15 exceeds the window and exercises the clamp, and a viol_need of 9 can never be met. The short settling count lets the blind start-up phase and its end both be seen within a few samples. An eight-deep history can be read back in full after every freeze, and a random phase mixes clears, masks and window settings against the behavioural model.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // Clamp a requested window length into 1..max_len.
  function automatic int win_clamp(int req, int max_len);
    if (req < 1) return 1;
    if (req > max_len) return max_len;
    return req;
  endfunction
endpackage

// File: rtl/ovl_limit_cmp.sv
module ovl_limit_cmp #(
  parameter int SAMPLE_W       = 16,
  parameter int SETTLE_SAMPLES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] data,
  input  logic [SAMPLE_W-1:0] lo,
  input  logic [SAMPLE_W-1:0] hi,
  output logic                viol
);
  localparam int SCW = $clog2(SETTLE_SAMPLES + 2);

  logic [SCW-1:0] settle_q;
  logic           settled;

  assign settled = (settle_q == SCW'(SETTLE_SAMPLES));

  always_ff @(posedge clk) begin
    if (rst) settle_q <= '0;
    else if (valid && !settled) settle_q <= settle_q + SCW'(1);
  end

  // Strict comparison: samples equal to a limit are in range (R2).
  assign viol = valid && settled && ((data > hi) || (data < lo));

  // R3: the settling counter only ever climbs up to its limit.
  assert_settle_mono_R3: assert property (@(posedge clk) disable iff (rst)
    settled |=> settled);
endmodule

// File: rtl/ovl_glitch_win.sv
module ovl_glitch_win
  import ovl_pkg::*;
#(
  parameter int WIN_MAX = 16,
  parameter int CW      = $clog2(WIN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          viol,
  input  logic          clear,
  input  logic          mask,
  input  logic [CW-1:0] need,
  input  logic [CW-1:0] win_len,
  output logic          fire,
  output logic          trip_pulse,
  output logic          trip_flag
);
  logic [WIN_MAX-1:0] win_q, win_nx;
  logic [CW-1:0]      weff, cnt;

  always_comb begin
    win_nx = {win_q[WIN_MAX-2:0], viol};
    weff   = CW'(win_clamp(int'(win_len), WIN_MAX));
    cnt    = '0;
    for (int i = 0; i < WIN_MAX; i++) begin
      if ((i < int'(weff)) && win_nx[i]) cnt = cnt + CW'(1);
    end
  end

  assign fire = valid && !clear && !trip_flag && !mask &&
                (need != '0) && (cnt >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q      <= '0;
      trip_pulse <= 1'b0;
      trip_flag  <= 1'b0;
    end else begin
      trip_pulse <= fire;
      if (clear) begin
        trip_flag <= 1'b0;
        win_q     <= '0;
      end else begin
        if (fire)  trip_flag <= 1'b1;
        if (valid) win_q     <= win_nx;
      end
    end
  end

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    trip_pulse |=> !trip_pulse);
  assert_pulse_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
    trip_pulse |-> $past(valid));
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    trip_pulse |-> !$past(mask));
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (trip_flag && !clear) |=> trip_flag);
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_flag) |-> trip_pulse);
endmodule

// File: rtl/ovl_history.sv
module ovl_history #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 8,
  parameter int PW       = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                freeze,
  input  logic                clear,
  input  logic [PW-1:0]       rd_idx,
  output logic [SAMPLE_W-1:0] rd_data
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PW-1:0]       wptr;
  logic                frozen;
  logic                wr_ok;

  assign wr_ok = wr_en && !frozen && !clear;

  // Storage without reset so that it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
    rd_data <= mem[wptr - PW'(1) - rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      frozen <= 1'b0;
    end else if (clear) begin
      frozen <= 1'b0;
    end else begin
      if (wr_ok)  wptr   <= wptr + PW'(1);
      if (freeze) frozen <= 1'b1;
    end
  end

  assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (frozen && !clear) |=> $stable(wptr));
  assert_freeze_on_trip_R8: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clear) |=> frozen);
endmodule

// File: rtl/ovl_trip_monitor.sv
module ovl_trip_monitor #(
  parameter int SAMPLE_W       = 16,
  parameter int WIN_MAX        = 16,
  parameter int SETTLE_SAMPLES = 16,
  parameter int HIST_DEPTH     = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            smp_valid,
  input  logic [SAMPLE_W-1:0]             smp_data,
  input  logic [SAMPLE_W-1:0]             lim_lo,
  input  logic [SAMPLE_W-1:0]             lim_hi,
  input  logic [$clog2(WIN_MAX+1)-1:0]    viol_need,
  input  logic [$clog2(WIN_MAX+1)-1:0]    win_len,
  input  logic                            trip_mask,
  input  logic                            trip_clear,
  input  logic [$clog2(HIST_DEPTH)-1:0]   hist_idx,
  output logic                            trip_pulse,
  output logic                            trip_flag,
  output logic [SAMPLE_W-1:0]             hist_data
);
  localparam int CW = $clog2(WIN_MAX + 1);
  localparam int PW = $clog2(HIST_DEPTH);

  logic viol, fire;

  ovl_limit_cmp #(.SAMPLE_W(SAMPLE_W), .SETTLE_SAMPLES(SETTLE_SAMPLES)) u_cmp (
    .clk(clk), .rst(rst), .valid(smp_valid), .data(smp_data),
    .lo(lim_lo), .hi(lim_hi), .viol(viol)
  );

  ovl_glitch_win #(.WIN_MAX(WIN_MAX), .CW(CW)) u_win (
    .clk(clk), .rst(rst), .valid(smp_valid), .viol(viol),
    .clear(trip_clear), .mask(trip_mask), .need(viol_need),
    .win_len(win_len), .fire(fire), .trip_pulse(trip_pulse),
    .trip_flag(trip_flag)
  );

  ovl_history #(.SAMPLE_W(SAMPLE_W), .DEPTH(HIST_DEPTH), .PW(PW)) u_hist (
    .clk(clk), .rst(rst), .wr_en(smp_valid), .wr_data(smp_data),
    .freeze(fire), .clear(trip_clear), .rd_idx(hist_idx),
    .rd_data(hist_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!trip_pulse && !trip_flag));
endmodule

// File: tb/tb_ovl_trip_monitor.sv
module tb_ovl_trip_monitor;
  localparam int SW = 16, WM = 8, ST = 4, HD = 8;
  localparam int CW = $clog2(WM + 1);
  localparam int HW = $clog2(HD);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, smp_valid = 1'b0, trip_mask = 1'b0, trip_clear = 1'b0;
  logic [SW-1:0] smp_data = '0, lim_lo = 16'd300, lim_hi = 16'd700;
  logic [CW-1:0] viol_need = CW'(1), win_len = CW'(1);
  logic [HW-1:0] hist_idx = '0;
  logic          trip_pulse, trip_flag;
  logic [SW-1:0] hist_data;

  ovl_trip_monitor #(.SAMPLE_W(SW), .WIN_MAX(WM), .SETTLE_SAMPLES(ST),
                     .HIST_DEPTH(HD)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit win_q[$];
  int hq[$];
  int scnt = 0;
  bit m_flag = 0, m_pulse = 0, m_frozen = 0;

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(bit v, int d, bit clr = 0);
    @(negedge clk);
    smp_valid = v; smp_data = SW'(d); trip_clear = clr;
    if (clr) begin
      m_flag = 0; m_frozen = 0; m_pulse = 0; win_q.delete();
    end else if (v) begin
      bit viol; int c, w; bit f;
      viol = (scnt >= ST) && (d > int'(lim_hi) || d < int'(lim_lo));
      if (scnt < ST) scnt++;
      win_q.push_front(viol);
      if (win_q.size() > WM) void'(win_q.pop_back());
      w = (win_len == 0) ? 1 : (int'(win_len) > WM ? WM : int'(win_len));
      c = 0;
      for (int i = 0; i < w && i < win_q.size(); i++) c += win_q[i];
      f = !m_flag && !trip_mask && viol_need != 0 && c >= int'(viol_need);
      if (!m_frozen) begin
        hq.push_front(d);
        if (hq.size() > HD) void'(hq.pop_back());
      end
      if (f) begin m_flag = 1; m_frozen = 1; end
      m_pulse = f;
    end else m_pulse = 0;
    @(posedge clk); #1;
    chk("R4", "trip_pulse", trip_pulse, m_pulse);
    chk("R6", "trip_flag", trip_flag, m_flag);
  endtask

  task automatic rd_hist(int idx, string tag);
    hist_idx = HW'(idx);
    step(0, 0);
    chk(tag, $sformatf("hist[%0d]", idx), int'(hist_data), idx < hq.size() ? hq[idx] : -1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "trip_pulse after reset", trip_pulse, 0);
    chk("R1", "trip_flag after reset", trip_flag, 0);

    // R3: settling samples far out of range never trip with need=1.
    for (int i = 0; i < ST; i++) step(1, 0);
    chk("R3", "flag after settle", trip_flag, 0);

    // R2: limits themselves are in range; one above trips.
    step(1, 300); step(1, 700);
    chk("R2", "equal to limit", trip_flag, 0);
    step(1, 701);
    chk("R2", "above upper pulse", trip_pulse, 1);
    step(1, 500);
    chk("R4", "pulse single cycle", trip_pulse, 0);
    step(0, 0, 1);
    chk("R6", "clear drops flag", trip_flag, 0);
    step(1, 299);
    chk("R2", "below lower pulse", trip_pulse, 1);
    step(0, 0, 1);

    // R4: four of four.
    viol_need = CW'(4); win_len = CW'(4);
    foreach (hq[i]) ;
    step(1, 1000); step(1, 1000); step(1, 1000); step(1, 500);
    step(1, 1000); step(1, 1000); step(1, 1000); step(1, 510);
    chk("R4", "broken runs no trip", trip_flag, 0);
    step(1, 1001); step(1, 1002); step(1, 1003); step(1, 1004);
    chk("R4", "fourth violation trips", trip_pulse, 1);
    step(1, 520);
    chk("R6", "flag sticky", trip_flag, 1);
    for (int i = 0; i < HD; i++) rd_hist(i, "R8");
    chk("R8", "newest is trip sample", hq[0], 1004);
    step(1, 123); step(1, 124); step(1, 125);
    rd_hist(0, "R8");
    chk("R8", "frozen newest", int'(hist_data), 1004);
    step(0, 0, 1);
    step(1, 450);
    rd_hist(0, "R8");
    chk("R8", "resumed after clear", int'(hist_data), 450);

    // R7: mask.
    viol_need = CW'(2); win_len = CW'(3); trip_mask = 1'b1;
    step(1, 1000); step(1, 1000); step(1, 999);
    chk("R7", "masked flag", trip_flag, 0);
    rd_hist(0, "R7");
    chk("R7", "history under mask", int'(hist_data), 999);
    trip_mask = 1'b0;
    step(1, 500);
    chk("R7", "window kept under mask", trip_pulse, 1);
    step(0, 0, 1);

    // R5: clamp and need=0.
    viol_need = CW'(2); win_len = CW'(0);
    step(1, 900); step(1, 900); step(1, 900);
    chk("R5", "win 0 acts as 1", trip_flag, 0);
    step(0, 0, 1);
    viol_need = CW'(9); win_len = CW'(15);
    for (int i = 0; i < 12; i++) step(1, 50);
    chk("R5", "win clamped to WIN_MAX", trip_flag, 0);
    step(0, 0, 1);
    viol_need = CW'(8);
    for (int i = 0; i < 8; i++) step(1, 50);
    chk("R5", "full window trips", trip_flag, 1);
    step(0, 0, 1);
    viol_need = CW'(0); win_len = CW'(4);
    for (int i = 0; i < 6; i++) step(1, 2000);
    chk("R5", "need 0 never trips", trip_flag, 0);
    step(0, 0, 1);

    // Random mix against the model.
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0) begin
        viol_need = CW'($urandom_range(1, 4));
        win_len   = CW'($urandom_range(0, 10));
        trip_mask = ($urandom_range(0, 5) == 0);
      end
      if (i % 53 == 52) step(0, 0, 1);
      else step($urandom_range(0, 3) != 0, $urandom_range(200, 800));
      if (i % 97 == 0) rd_hist($urandom_range(0, HD - 1), "R8");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule